// File: doc/BRIEF.md
# Queue Controller Register File with Doorbells

This block is the memory-mapped register front end of a queue-based storage controller. It holds the read-only capability and version words, an interrupt mask with separate set and clear offsets, a configuration word, a status word, and the admin queue attributes and 64-bit base addresses. Host writes to the configuration word drive a small state machine. The machine validates the setup when the enable bit rises, removes all queues when enable falls, and reports shutdown completion when the shutdown field changes.

Writes at or above offset 0x1000 are treated as doorbells. Each aligned dword in that region is a submission-queue tail or a completion-queue head for one queue. A doorbell is accepted only when the queue exists and the value fits the queue. Each accepted doorbell leaves the block as a one-cycle strobe with the queue id and the value. A per-queue table of valid bits and entry counts holds the queue state. The admin pair (queue 0) is filled in when validation passes, and an external create/delete port sets up the other queues. The block also provides the page size and entry sizes derived from the configuration word.

The state machine has four states. ST_OFF is the disabled state. ST_CHECK is a single validation cycle. ST_RUN is the enabled state with ready set. ST_FAULT is the enabled state with the fatal bit set. The transitions are as follows. Enable-rise goes from ST_OFF to ST_CHECK. Pass goes from ST_CHECK to ST_RUN and creates the admin queues. Fail goes from ST_CHECK to ST_FAULT. Enable-fall goes from ST_RUN or ST_FAULT to ST_OFF and tears down all queues. A configuration write that arrives during ST_CHECK is dropped.

Top module: `qctl_regfile`

## Requirements
- R1: After reset the register reads are: 0x00 = 0x0F0107FF (entry limit 0x7FF in bits 15:0, contiguous-queue flag bit 16, timeout 0x0F in bits 31:24); 0x04 = 0x00400000 (minimum page code 0 in bits 19:16, maximum page code 4 in bits 23:20); 0x08 = 0x00010100. Status (0x1C) and interrupt mask read 0.
- R2: A write to 0x0C ORs its data into the interrupt mask. A write to 0x10 clears the bits that are set in its data. Reads of either offset return the mask.
- R3: The admin attributes (0x24; submission entries-1 in bits 11:0, completion entries-1 in bits 27:16) and the admin base dwords (submission 0x28 low and 0x2C high, completion 0x30 low and 0x34 high) store what is written and read it back.
- R4: Configuration (0x14) field layout: enable bit 0, page code bits 10:7, shutdown bits 15:14, submission entry code bits 19:16, completion entry code bits 23:20. The word stores a written value while enable and shutdown are 0 both before and after the write. While enable stays 1 and the shutdown field does not change, a write leaves the word unchanged.
- R5: When enable rises and the setup is valid, status bit 0 (ready) becomes 1 two cycles after the write, and bit 1 (fatal) becomes 0. Queue 0 then exists with attribute+1 entries in each direction.
- R6: Validation fails if any of these holds: an admin base is zero; an admin base is not aligned to the page; the page code is outside 0..4; the submission entry code is not 6; the completion entry code is not 4; an attribute count is zero. A failure sets fatal and leaves ready at 0.
- R7: When enable falls, ready clears, the configuration word reads 0, a one-cycle teardown pulse is issued, and every queue is removed.
- R8: When the shutdown field goes from zero to nonzero, status bits 3:2 become 2'b10 and all queues are removed. When the field returns to zero, bits 3:2 clear.
- R9: An aligned doorbell write at address A ≥ 0x1000 has index k=(A-0x1000)/4. An even k is the submission tail of queue k/2, and an odd k is the completion head of queue k/2. The strobe appears in the cycle after the write and carries the low 16 bits of the data.
- R10: A doorbell write produces no strobe in any of these cases: the address is not dword aligned, the queue id is 64 or more, the queue does not exist, or the value is at or above the queue's entry count.
- R11: The page-size output is 2^(12+page code). The entry-size outputs are 2^(submission code) and 2^(completion code).
- R12: A create pulse sets a queue's valid bit and entry count for the selected direction. A delete pulse clears the valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register or doorbell write strobe |
| wr_addr | input | 16 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 16 | Byte offset of the read |
| rd_data | output | 32 | Combinational read data |
| qc_en | input | 1 | Queue create/delete pulse |
| qc_is_cq | input | 1 | 1 selects the completion queue, 0 the submission queue |
| qc_create | input | 1 | 1 creates the queue, 0 deletes it |
| qc_id | input | 6 | Queue id for the create or delete |
| qc_size | input | 16 | Entry count for a create |
| db_stb | output | 1 | Accepted doorbell strobe |
| db_is_cq | output | 1 | 1 for a completion head, 0 for a submission tail |
| db_qid | output | 6 | Queue id of the doorbell |
| db_val | output | 16 | New tail or head value |
| ctl_ready | output | 1 | Ready status |
| ctl_fatal | output | 1 | Fatal status |
| q_teardown | output | 1 | One-cycle pulse that removes all queues |
| page_bytes | output | 32 | Page size in bytes |
| sqe_bytes | output | 16 | Submission entry size in bytes |
| cqe_bytes | output | 16 | Completion entry size in bytes |

## Verification
The assertions check four things on every cycle. Ready and fatal are never set together. Ready only rises out of the validation cycle. Ready drops after a disabling write. Every strobe follows a write one cycle earlier and carries its data. They also check that the mask holds the bits just set, that shutdown completion rises only on a configuration write, and that a teardown leaves the queue table empty.

Other behaviour can only be shown by the bench's scenarios. These cover the exact index-to-queue mapping of doorbells, each of the rejection conditions, each validation failure, the handling of configuration writes while enabled, and the derived sizes. The scenarios drive directed sequences and randomly mixed create and doorbell traffic, and compare the results against a queue model kept in the bench.

// File: rtl/qrf_pkg.sv
package qrf_pkg;
    localparam logic [11:0] OFS_CAP_LO = 12'h000;
    localparam logic [11:0] OFS_CAP_HI = 12'h004;
    localparam logic [11:0] OFS_VER    = 12'h008;
    localparam logic [11:0] OFS_MSET   = 12'h00C;
    localparam logic [11:0] OFS_MCLR   = 12'h010;
    localparam logic [11:0] OFS_CFG    = 12'h014;
    localparam logic [11:0] OFS_STAT   = 12'h01C;
    localparam logic [11:0] OFS_AQA    = 12'h024;
    localparam logic [11:0] OFS_ASQ_LO = 12'h028;
    localparam logic [11:0] OFS_ASQ_HI = 12'h02C;
    localparam logic [11:0] OFS_ACQ_LO = 12'h030;
    localparam logic [11:0] OFS_ACQ_HI = 12'h034;

    localparam logic [3:0] PG_MIN   = 4'd0;
    localparam logic [3:0] PG_MAX   = 4'd4;
    localparam logic [3:0] SQE_CODE = 4'd6;
    localparam logic [3:0] CQE_CODE = 4'd4;

    localparam logic [31:0] CAP_LO  = {8'h0F, 5'd0, 2'd0, 1'b1, 16'h07FF};
    localparam logic [31:0] CAP_HI  = {8'd0, PG_MAX, PG_MIN, 16'd0};
    localparam logic [31:0] VERSION = 32'h0001_0100;

    typedef enum logic [1:0] {ST_OFF, ST_CHECK, ST_RUN, ST_FAULT} ctl_state_t;

    typedef struct packed {
        logic [7:0] rsv_hi;
        logic [3:0] cqe;
        logic [3:0] sqe;
        logic [1:0] shn;
        logic [2:0] arb;
        logic [3:0] pg;
        logic [2:0] cset;
        logic [2:0] rsv_lo;
        logic       en;
    } cfg_t;
endpackage

// File: rtl/qrf_ctl_fsm.sv
module qrf_ctl_fsm
    import qrf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [31:0] wdata,
    input  logic [63:0] asq_base,
    input  logic [63:0] acq_base,
    input  logic [11:0] asq_ents,
    input  logic [11:0] acq_ents,
    output cfg_t        cfg_q,
    output logic        ready,
    output logic        fatal,
    output logic        shdn_done,
    output logic        teardown,
    output logic        admin_create
);
    ctl_state_t st, st_n;
    cfg_t       wd, cfg_n;
    logic       rdy_n, ftl_n, shd_n, td_n, ac_n;
    logic       en_r, en_f, sh_r, sh_f, idle, pass;
    logic [63:0] pg_mask;

    assign wd = cfg_t'(wdata);

    always_comb begin
        en_r = wd.en & ~cfg_q.en;
        en_f = ~wd.en & cfg_q.en;
        sh_r = (|wd.shn) & ~(|cfg_q.shn);
        sh_f = ~(|wd.shn) & (|cfg_q.shn);
        idle = ~wd.en & ~cfg_q.en & ~(|wd.shn) & ~(|cfg_q.shn);
        pg_mask = (64'd1 << (32'd12 + 32'(cfg_q.pg))) - 64'd1;
        pass = (asq_base != '0) && (acq_base != '0)
            && ((asq_base & pg_mask) == '0) && ((acq_base & pg_mask) == '0)
            && (cfg_q.pg >= PG_MIN) && (cfg_q.pg <= PG_MAX)
            && (cfg_q.sqe == SQE_CODE) && (cfg_q.cqe == CQE_CODE)
            && (asq_ents != '0) && (acq_ents != '0);
    end

    // next state and next outputs
    always_comb begin
        st_n  = st;
        cfg_n = cfg_q;
        rdy_n = ready;
        ftl_n = fatal;
        shd_n = shdn_done;
        td_n  = 1'b0;
        ac_n  = 1'b0;
        unique case (st)
            ST_CHECK: begin
                if (pass) begin
                    st_n  = ST_RUN;
                    rdy_n = 1'b1;
                    ftl_n = 1'b0;
                    ac_n  = 1'b1;
                end else begin
                    st_n  = ST_FAULT;
                    rdy_n = 1'b0;
                    ftl_n = 1'b1;
                end
            end
            ST_OFF, ST_RUN, ST_FAULT: begin
                if (cfg_wr) begin
                    if (sh_r || sh_f || en_r || idle) cfg_n = wd;
                    else if (en_f)                    cfg_n = '0;
                    if (en_r) st_n = ST_CHECK;
                    else if (en_f) begin
                        st_n  = ST_OFF;
                        rdy_n = 1'b0;
                    end
                    td_n = en_f | sh_r;
                    if (sh_r)      shd_n = 1'b1;
                    else if (sh_f) shd_n = 1'b0;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= st_n;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q        <= '0;
            ready        <= 1'b0;
            fatal        <= 1'b0;
            shdn_done    <= 1'b0;
            teardown     <= 1'b0;
            admin_create <= 1'b0;
        end else begin
            cfg_q        <= cfg_n;
            ready        <= rdy_n;
            fatal        <= ftl_n;
            shdn_done    <= shd_n;
            teardown     <= td_n;
            admin_create <= ac_n;
        end
    end

    a_r5_ready_fatal_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && fatal));
    a_r5_ready_from_check: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(st == ST_CHECK));
    a_r7_disable_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !wdata[0] && cfg_q.en && st != ST_CHECK) |=> !ready);
    a_r8_shdn_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shdn_done) |-> $past(cfg_wr));
endmodule

// File: rtl/qrf_qtable.sv
module qrf_qtable #(
    parameter int NQ = 64,
    parameter int QW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 teardown,
    input  logic                 admin_create,
    input  logic [15:0]          admin_sq_ents,
    input  logic [15:0]          admin_cq_ents,
    input  logic                 qc_en,
    input  logic                 qc_is_cq,
    input  logic                 qc_create,
    input  logic [QW-1:0]        qc_id,
    input  logic [15:0]          qc_size,
    output logic [NQ-1:0]        sq_valid,
    output logic [NQ-1:0]        cq_valid,
    output logic [NQ-1:0][15:0]  sq_size,
    output logic [NQ-1:0][15:0]  cq_size
);
    for (genvar i = 0; i < NQ; i++) begin : g_q
        logic        sv, cv;
        logic [15:0] ss, cs;
        logic        hit;
        assign hit = qc_en && (qc_id == QW'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sv <= 1'b0;
                cv <= 1'b0;
                ss <= '0;
                cs <= '0;
            end else if (teardown) begin
                sv <= 1'b0;
                cv <= 1'b0;
            end else if (admin_create && i == 0) begin
                sv <= 1'b1;
                cv <= 1'b1;
                ss <= admin_sq_ents;
                cs <= admin_cq_ents;
            end else if (hit) begin
                if (qc_is_cq) begin
                    cv <= qc_create;
                    if (qc_create) cs <= qc_size;
                end else begin
                    sv <= qc_create;
                    if (qc_create) ss <= qc_size;
                end
            end
        end

        assign sq_valid[i] = sv;
        assign cq_valid[i] = cv;
        assign sq_size[i]  = ss;
        assign cq_size[i]  = cs;
    end

    a_r7_teardown_empties: assert property (@(posedge clk) disable iff (!rst_n)
        teardown |=> (sq_valid == '0 && cq_valid == '0));
    a_r12_create_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (qc_en && qc_create && !teardown && !admin_create && !qc_is_cq)
            |=> sq_valid[$past(qc_id)]);
endmodule

// File: rtl/qrf_doorbell.sv
module qrf_doorbell #(
    parameter int NQ     = 64,
    parameter int QW     = 6,
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [15:0]          wr_val,
    input  logic [NQ-1:0]        sq_valid,
    input  logic [NQ-1:0]        cq_valid,
    input  logic [NQ-1:0][15:0]  sq_size,
    input  logic [NQ-1:0][15:0]  cq_size,
    output logic                 db_stb,
    output logic                 db_is_cq,
    output logic [QW-1:0]        db_qid,
    output logic [15:0]          db_val
);
    localparam logic [ADDR_W-1:0] DB_BASE = ADDR_W'(32'h1000);
    localparam int IW = ADDR_W - 2;
    localparam int SW = ADDR_W - 3;

    logic [ADDR_W-1:0] off;
    logic [IW-1:0]     idx;
    logic [SW-1:0]     qsel;
    logic [QW-1:0]     qid;
    logic              is_cq, exists, hit;
    logic [15:0]       limit;

    always_comb begin
        off    = wr_addr - DB_BASE;
        idx    = off[ADDR_W-1:2];
        qsel   = idx[IW-1:1];
        is_cq  = idx[0];
        qid    = qsel[QW-1:0];
        exists = is_cq ? cq_valid[qid] : sq_valid[qid];
        limit  = is_cq ? cq_size[qid] : sq_size[qid];
        hit    = wr_en && (wr_addr >= DB_BASE) && (wr_addr[1:0] == 2'b00)
              && (qsel < SW'(NQ)) && exists && (wr_val < limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            db_stb   <= 1'b0;
            db_is_cq <= 1'b0;
            db_qid   <= '0;
            db_val   <= '0;
        end else begin
            db_stb <= hit;
            if (hit) begin
                db_is_cq <= is_cq;
                db_qid   <= qid;
                db_val   <= wr_val;
            end
        end
    end

    a_r9_strobe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        db_stb |-> ($past(wr_en) && db_val == $past(wr_val)));
endmodule

// File: rtl/qctl_regfile.sv
module qctl_regfile
    import qrf_pkg::*;
#(
    parameter int NQ     = 64,
    parameter int ADDR_W = 16,
    localparam int QW    = $clog2(NQ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              qc_en,
    input  logic              qc_is_cq,
    input  logic              qc_create,
    input  logic [QW-1:0]     qc_id,
    input  logic [15:0]       qc_size,
    output logic              db_stb,
    output logic              db_is_cq,
    output logic [QW-1:0]     db_qid,
    output logic [15:0]       db_val,
    output logic              ctl_ready,
    output logic              ctl_fatal,
    output logic              q_teardown,
    output logic [31:0]       page_bytes,
    output logic [15:0]       sqe_bytes,
    output logic [15:0]       cqe_bytes
);
    logic        reg_wr, rd_reg, shdn_done, admin_create;
    logic [11:0] wofs;
    logic [31:0] imask, aqa;
    logic [63:0] asq, acq;
    cfg_t        cfg_q;
    logic [NQ-1:0]       sq_valid, cq_valid;
    logic [NQ-1:0][15:0] sq_size, cq_size;

    assign reg_wr = wr_en && (wr_addr[ADDR_W-1:12] == '0);
    assign rd_reg = (rd_addr[ADDR_W-1:12] == '0);
    assign wofs   = wr_addr[11:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imask <= '0;
            aqa   <= '0;
            asq   <= '0;
            acq   <= '0;
        end else if (reg_wr) begin
            case (wofs)
                OFS_MSET:   imask       <= imask | wr_data;
                OFS_MCLR:   imask       <= imask & ~wr_data;
                OFS_AQA:    aqa         <= wr_data;
                OFS_ASQ_LO: asq[31:0]   <= wr_data;
                OFS_ASQ_HI: asq[63:32]  <= wr_data;
                OFS_ACQ_LO: acq[31:0]   <= wr_data;
                OFS_ACQ_HI: acq[63:32]  <= wr_data;
                default: ;
            endcase
        end
    end

    qrf_ctl_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (reg_wr && wofs == OFS_CFG),
        .wdata        (wr_data),
        .asq_base     (asq),
        .acq_base     (acq),
        .asq_ents     (aqa[11:0]),
        .acq_ents     (aqa[27:16]),
        .cfg_q        (cfg_q),
        .ready        (ctl_ready),
        .fatal        (ctl_fatal),
        .shdn_done    (shdn_done),
        .teardown     (q_teardown),
        .admin_create (admin_create)
    );

    qrf_qtable #(.NQ(NQ), .QW(QW)) i_qtab (
        .clk           (clk),
        .rst_n         (rst_n),
        .teardown      (q_teardown),
        .admin_create  (admin_create),
        .admin_sq_ents (16'(aqa[11:0]) + 16'd1),
        .admin_cq_ents (16'(aqa[27:16]) + 16'd1),
        .qc_en         (qc_en),
        .qc_is_cq      (qc_is_cq),
        .qc_create     (qc_create),
        .qc_id         (qc_id),
        .qc_size       (qc_size),
        .sq_valid      (sq_valid),
        .cq_valid      (cq_valid),
        .sq_size       (sq_size),
        .cq_size       (cq_size)
    );

    qrf_doorbell #(.NQ(NQ), .QW(QW), .ADDR_W(ADDR_W)) i_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_val   (wr_data[15:0]),
        .sq_valid (sq_valid),
        .cq_valid (cq_valid),
        .sq_size  (sq_size),
        .cq_size  (cq_size),
        .db_stb   (db_stb),
        .db_is_cq (db_is_cq),
        .db_qid   (db_qid),
        .db_val   (db_val)
    );

    assign page_bytes = 32'd1 << (5'd12 + {1'b0, cfg_q.pg});
    assign sqe_bytes  = 16'd1 << cfg_q.sqe;
    assign cqe_bytes  = 16'd1 << cfg_q.cqe;

    always_comb begin
        rd_data = '0;
        if (rd_reg) begin
            case (rd_addr[11:0])
                OFS_CAP_LO:         rd_data = CAP_LO;
                OFS_CAP_HI:         rd_data = CAP_HI;
                OFS_VER:            rd_data = VERSION;
                OFS_MSET, OFS_MCLR: rd_data = imask;
                OFS_CFG:            rd_data = cfg_q;
                OFS_STAT:           rd_data = {28'd0, shdn_done, 1'b0, ctl_fatal, ctl_ready};
                OFS_AQA:            rd_data = aqa;
                OFS_ASQ_LO:         rd_data = asq[31:0];
                OFS_ASQ_HI:         rd_data = asq[63:32];
                OFS_ACQ_LO:         rd_data = acq[31:0];
                OFS_ACQ_HI:         rd_data = acq[63:32];
                default:            rd_data = '0;
            endcase
        end
    end

    a_r2_mask_set_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && wofs == OFS_MSET) |=> ((imask & $past(wr_data)) == $past(wr_data)));
    a_r2_mask_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && wofs == OFS_MCLR) |=> ((imask & $past(wr_data)) == '0));
endmodule

// File: tb/test_qctl_regfile.sv
module test_qctl_regfile;
    localparam int NQ = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        qc_en = 1'b0, qc_is_cq = 1'b0, qc_create = 1'b0;
    logic [5:0]  qc_id = '0;
    logic [15:0] qc_size = '0;
    logic        db_stb, db_is_cq, ctl_ready, ctl_fatal, q_teardown;
    logic [5:0]  db_qid;
    logic [15:0] db_val, sqe_bytes, cqe_bytes;
    logic [31:0] page_bytes;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    bit      m_sv[NQ];
    bit      m_cv[NQ];
    int      m_ss[NQ];
    int      m_cs[NQ];

    always #4 clk = ~clk;

    qctl_regfile i_qctl_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .qc_en(qc_en), .qc_is_cq(qc_is_cq),
        .qc_create(qc_create), .qc_id(qc_id), .qc_size(qc_size), .db_stb(db_stb),
        .db_is_cq(db_is_cq), .db_qid(db_qid), .db_val(db_val), .ctl_ready(ctl_ready),
        .ctl_fatal(ctl_fatal), .q_teardown(q_teardown), .page_bytes(page_bytes),
        .sqe_bytes(sqe_bytes), .cqe_bytes(cqe_bytes)
    );

    function automatic logic [31:0] cfg_word(input bit en, input int pg, input int sh,
                                             input int sqe, input int cqe);
        return (32'(cqe) << 20) | (32'(sqe) << 16) | (32'(sh) << 14) | (32'(pg) << 7) | 32'(en);
    endfunction

    function automatic bit db_expect(input int addr, input int val);
        int k, q;
        if (addr < 'h1000 || (addr % 4) != 0) return 0;
        k = (addr - 'h1000) / 4;
        q = k / 2;
        if (q >= NQ) return 0;
        if (k % 2 == 1) return m_cv[q] && val < m_cs[q];
        return m_sv[q] && val < m_ss[q];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic qc(input bit cq, input bit create, input int id, input int size);
        @(negedge clk);
        qc_en = 1'b1; qc_is_cq = cq; qc_create = create; qc_id = 6'(id); qc_size = 16'(size);
        @(negedge clk);
        qc_en = 1'b0;
        if (cq) begin m_cv[id] = create; if (create) m_cs[id] = size; end
        else    begin m_sv[id] = create; if (create) m_ss[id] = size; end
    endtask

    task automatic doorbell(input string req, input int addr, input int val);
        bit e;
        e = db_expect(addr, val);
        wr(16'(addr), 32'(val) | 32'hABCD_0000);
        check(req, {31'd0, db_stb}, {31'd0, e});
        if (e && db_stb) begin
            check(req, {31'd0, db_is_cq}, {31'd0, 1'(((addr - 'h1000) / 4) % 2)});
            check(req, {26'd0, db_qid}, 32'((addr - 'h1000) / 8));
            check(req, {16'd0, db_val}, 32'(val));
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < NQ; i++) begin m_sv[i] = 0; m_cv[i] = 0; end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        clear_model();
        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R1 reset values
        rd(16'h0000, v); check("R1 cap lo", v, 32'h0F0107FF);
        rd(16'h0004, v); check("R1 cap hi", v, 32'h00400000);
        rd(16'h0008, v); check("R1 version", v, 32'h00010100);
        rd(16'h001C, v); check("R1 status", v, 32'h0);
        rd(16'h000C, v); check("R1 mask", v, 32'h0);

        // R2 interrupt mask
        wr(16'h000C, 32'h0000_00F0); rd(16'h000C, v); check("R2 set", v, 32'h0000_00F0);
        wr(16'h000C, 32'h0000_000F); rd(16'h0010, v); check("R2 set or", v, 32'h0000_00FF);
        wr(16'h0010, 32'h0000_0030); rd(16'h000C, v); check("R2 clear", v, 32'h0000_00CF);

        // R3 admin attributes and bases
        wr(16'h0024, 32'h0003_0007); rd(16'h0024, v); check("R3 aqa", v, 32'h0003_0007);
        wr(16'h0028, 32'h0001_0800); rd(16'h0028, v); check("R3 asq lo", v, 32'h0001_0800);
        wr(16'h002C, 32'h0000_0000); rd(16'h002C, v); check("R3 asq hi", v, 32'h0);
        wr(16'h0030, 32'h0002_0000); rd(16'h0030, v); check("R3 acq lo", v, 32'h0002_0000);
        wr(16'h0034, 32'h0000_0001); rd(16'h0034, v); check("R3 acq hi", v, 32'h1);
        wr(16'h0034, 32'h0000_0000);

        // R4 store while idle, R11 derived sizes
        wr(16'h0014, cfg_word(0, 1, 0, 6, 4)); rd(16'h0014, v);
        check("R4 idle store", v, cfg_word(0, 1, 0, 6, 4));
        check("R11 page", page_bytes, 32'd8192);
        check("R11 sqe", {16'd0, sqe_bytes}, 32'd64);
        check("R11 cqe", {16'd0, cqe_bytes}, 32'd16);
        wr(16'h0014, cfg_word(0, 0, 0, 6, 4));
        check("R11 page 4k", page_bytes, 32'd4096);

        // R6 misaligned admin base -> fatal
        wr(16'h0014, cfg_word(1, 0, 0, 6, 4)); settle(2);
        rd(16'h001C, v); check("R6 misaligned base", v, 32'h2);
        doorbell("R6 no admin queue", 'h1000, 1);
        wr(16'h0014, cfg_word(0, 0, 0, 6, 4));
        rd(16'h001C, v); check("R7 disable clears ready", v & 32'h1, 32'h0);
        rd(16'h0014, v); check("R7 cfg zero", v, 32'h0);

        // R6 bad entry code -> fatal
        wr(16'h0028, 32'h0001_0000);
        wr(16'h0014, cfg_word(1, 0, 0, 5, 4)); settle(2);
        rd(16'h001C, v); check("R6 entry code", v, 32'h2);
        wr(16'h0014, cfg_word(0, 0, 0, 5, 4));
        // R6 page code above 4
        wr(16'h0014, cfg_word(1, 5, 0, 6, 4)); settle(2);
        rd(16'h001C, v); check("R6 page code", v, 32'h2);
        wr(16'h0014, 32'h0);

        // R5 good enable
        wr(16'h0014, cfg_word(1, 0, 0, 6, 4)); settle(3);
        rd(16'h001C, v); check("R5 ready", v, 32'h1);
        check("R5 ready pin", {31'd0, ctl_ready}, 32'h1);
        m_sv[0] = 1; m_ss[0] = 8; m_cv[0] = 1; m_cs[0] = 4;
        doorbell("R9 admin sq tail", 'h1000, 5);
        doorbell("R9 admin cq head", 'h1004, 3);
        doorbell("R10 value at size", 'h1004, 4);
        doorbell("R10 misaligned", 'h1002, 1);

        // R4 write ignored while enabled
        wr(16'h0014, cfg_word(1, 2, 0, 6, 4)); rd(16'h0014, v);
        check("R4 hold while enabled", v, cfg_word(1, 0, 0, 6, 4));
        check("R4 page unchanged", page_bytes, 32'd4096);

        // R12 create / delete
        qc(0, 1, 5, 16);
        doorbell("R12 created sq", 'h1028, 15);
        doorbell("R10 sq at size", 'h1028, 16);
        doorbell("R10 cq absent", 'h102C, 1);
        qc(0, 0, 5, 0);
        doorbell("R12 deleted sq", 'h1028, 2);
        doorbell("R10 qid 64", 'h1200, 0);

        // R9 R10 random traffic
        for (int it = 0; it < 400; it++) begin
            int q, a, val;
            if (($urandom % 4) == 0) begin
                qc($urandom % 2, ($urandom % 4) != 0, $urandom % 8, 1 + $urandom % 20);
            end else begin
                q = ($urandom % 10 == 0) ? 64 + $urandom % 4 : $urandom % 8;
                a = 'h1000 + q * 8 + (($urandom % 2) * 4);
                if ($urandom % 8 == 0) a = a + 2;
                val = $urandom % 24;
                doorbell("R9 R10 random", a, val);
            end
        end

        // R8 shutdown edges
        wr(16'h0014, cfg_word(1, 0, 1, 6, 4));
        check("R8 teardown pulse", {31'd0, q_teardown}, 32'h1);
        clear_model();
        settle(1);
        rd(16'h001C, v); check("R8 shutdown done", v, 32'h9);
        doorbell("R8 queues removed", 'h1000, 1);
        wr(16'h0014, cfg_word(1, 0, 0, 6, 4));
        rd(16'h001C, v); check("R8 shutdown cleared", v, 32'h1);

        // R7 disable
        qc(1, 1, 3, 10);
        wr(16'h0014, cfg_word(0, 0, 0, 6, 4));
        check("R7 teardown pulse", {31'd0, q_teardown}, 32'h1);
        clear_model();
        settle(1);
        rd(16'h001C, v); check("R7 status", v, 32'h0);
        doorbell("R7 queues removed", 'h101C, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule